// File: doc/BRIEF.md
# Paged Memory Access Controller with Write-Cycle Counters

This block guards a 32-page address space of 32-byte pages. The regions have different access rights. General data pages can be read freely. Secret pages accept data but never show it on the external read port. One page is a staging scratchpad, and a group of read-only pages exposes hardware counters. External byte writes land only in the scratchpad. A commit strobe then copies the whole scratchpad into a chosen data or secret page in one cycle.

Each commit into a protected data page, or into a secret page, bumps a 32-bit write-cycle counter in hardware. There is one counter per protected data page and one per 64-bit secret. A separate 32-bit counter advances once for every cycle in which the hash-engine start input is high. The hash engine reads secret bytes over a dedicated combinational port that the external side cannot reach.

An address is 10 bits wide: the page number is in bits [9:5] and the byte offset is in bits [4:0].

Top module: `paged_access_ctrl`

## Requirements
- R1: Asynchronous active-low reset clears all data pages, secrets, the scratchpad and every counter to zero, and holds `rd_data` at 0x00.
- R2: `rd_data` is registered. One cycle after an address is presented, it holds the byte at that address as it stood before that clock edge. Pages 0 to 15 return their stored byte. A commit copies the scratchpad contents from before that cycle's write into the target page.
- R3: An external write takes effect only when the page is 18, the scratchpad, where it stores `wr_data` at the given offset. Writes to any other page, including data, secret and counter pages, change nothing.
- R4: Reads of pages 16 and 17 return 0xFF on `rd_data`. `sec_data` returns secret byte `sec_addr`, which is page 16 or 17 byte `sec_addr[4:0]`, chosen by `sec_addr[5]`.
- R5: A commit into page P, where P is 8 to 15, increments write-cycle counter P-8 by exactly one, whatever the number of bytes written beforehand. Commits into pages 0 to 7 touch no counter.
- R6: A commit into page 16+s increments counters 8+4s through 11+4s by one each. These are the counters of the four 8-byte secrets held in that page.
- R7: Counter k is read on page 19+(k/8) at byte offsets 4(k%8) to 4(k%8)+3, least significant byte first.
- R8: Each clock cycle with `hash_start` high increments the hash counter by one. Its bytes are read least significant first at offsets 0 to 3 of page 21. Offsets 4 to 31 of that page read 0x00.
- R9: Pages 22 to 31 read 0xFF.
- R10: A commit naming page 18 or above changes no memory and no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 10 | Byte address for reads and writes: page in [9:5], offset in [4:0] |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |
| copy_go | input | 1 | Commit scratchpad to `copy_page` |
| copy_page | input | 5 | Commit target page |
| hash_start | input | 1 | Hash-engine start pulse |
| sec_addr | input | 6 | Internal secret byte index |
| sec_data | output | 8 | Internal secret byte |

## Verification
The bench targets secret leakage: a design that decodes pages 16 and 17 as data would echo committed secrets on `rd_data` instead of 0xFF. It issues direct writes to data and counter pages. A design that lets those through would show altered bytes or counters on the next read. Repeated commits to one page check that counters step once per commit and not per byte, and that secret commits bump exactly four counters in the right half of page 20. Commits combined with a scratchpad write in the same cycle, commits to pages 18 and up, and hash pulses that overlap commits expose designs that copy the new byte, corrupt pages or lose a hash count.

// File: rtl/paged_access_ctrl.sv
module paged_access_ctrl #(
  parameter int OFF_W  = 5,
  parameter int PAGE_W = 5,
  parameter int CNT_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [PAGE_W+OFF_W-1:0]   addr,
  input  logic                      wr_en,
  input  logic [7:0]                wr_data,
  output logic [7:0]                rd_data,
  input  logic                      copy_go,
  input  logic [PAGE_W-1:0]         copy_page,
  input  logic                      hash_start,
  input  logic [OFF_W:0]            sec_addr,
  output logic [7:0]                sec_data
);
  localparam int PB = 1 << OFF_W;
  localparam logic [PAGE_W-1:0] SP_PG   = PAGE_W'(18);
  localparam logic [PAGE_W-1:0] CNT_PG0 = PAGE_W'(19);
  localparam logic [PAGE_W-1:0] CNT_PG1 = PAGE_W'(20);
  localparam logic [PAGE_W-1:0] HASH_PG = PAGE_W'(21);

  logic [15:0][PB-1:0][7:0] data_mem;
  logic [1:0][PB-1:0][7:0]  sec_mem;
  logic [PB-1:0][7:0]       sp;
  logic [15:0][CNT_W-1:0]   wcnt;
  logic [CNT_W-1:0]         hcnt;
  logic [7:0]               rd_next;

  wire [PAGE_W-1:0] pg  = addr[PAGE_W+OFF_W-1:OFF_W];
  wire [OFF_W-1:0]  off = addr[OFF_W-1:0];

  assign sec_data = sec_mem[sec_addr[OFF_W]][sec_addr[OFF_W-1:0]];

  always_comb begin
    rd_next = 8'hFF;
    if (!pg[4]) rd_next = data_mem[pg[3:0]][off];
    else begin
      case (pg)
        SP_PG:            rd_next = sp[off];
        CNT_PG0, CNT_PG1: rd_next = wcnt[{pg == CNT_PG1, off[4:2]}][{off[1:0], 3'b000} +: 8];
        HASH_PG:          rd_next = (off < 5'd4) ? hcnt[{off[1:0], 3'b000} +: 8] : 8'h00;
        default:          rd_next = 8'hFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_mem <= '0;
      sec_mem  <= '0;
      sp       <= '0;
      wcnt     <= '0;
      hcnt     <= '0;
      rd_data  <= 8'h00;
    end else begin
      rd_data <= rd_next;
      if (copy_go) begin
        if (!copy_page[4]) begin
          data_mem[copy_page[3:0]] <= sp;
          if (copy_page[3])
            wcnt[{1'b0, copy_page[2:0]}] <= wcnt[{1'b0, copy_page[2:0]}] + CNT_W'(1);
        end else if (copy_page[4:1] == 4'b1000) begin
          sec_mem[copy_page[0]] <= sp;
          for (int k = 0; k < 4; k++)
            wcnt[{1'b1, copy_page[0], 2'(k)}] <= wcnt[{1'b1, copy_page[0], 2'(k)}] + CNT_W'(1);
        end
      end
      if (wr_en && pg == SP_PG) sp[off] <= wr_data;
      if (hash_start) hcnt <= hcnt + CNT_W'(1);
    end
  end

  assert_secret_hidden_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pg[4:1] == 4'b1000) |=> (rd_data == 8'hFF));

  assert_high_pages_ff_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pg > HASH_PG) |=> (rd_data == 8'hFF));

  assert_data_only_by_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_go |=> $stable(data_mem) && $stable(sec_mem));

  assert_counters_only_by_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_go |=> $stable(wcnt));

  assert_high_copy_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_go && copy_page >= SP_PG) |=> $stable(data_mem) && $stable(wcnt));

  assert_hash_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hash_start |=> (hcnt == $past(hcnt) + CNT_W'(1)));

  assert_hash_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hash_start |=> $stable(hcnt));
endmodule

// File: tb/test_paged_access_ctrl.sv
`timescale 1ns/1ps
module test_paged_access_ctrl;
  logic clk = 0, rst_n = 0;
  logic [9:0] addr = '0;
  logic wr_en = 0, copy_go = 0, hash_start = 0;
  logic [7:0] wr_data = '0;
  logic [4:0] copy_page = '0;
  logic [5:0] sec_addr = '0;
  logic [7:0] rd_data, sec_data;

  paged_access_ctrl i_paged_access_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .copy_go(copy_go), .copy_page(copy_page),
    .hash_start(hash_start), .sec_addr(sec_addr), .sec_data(sec_data));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  byte unsigned dm[512], sm[64], spm[32];
  int unsigned wc[16], hc;

  function automatic byte unsigned mread(int a);
    int p = a >> 5, o = a & 31;
    if (p < 16) return dm[p*32 + o];
    if (p < 18) return 8'hFF;
    if (p == 18) return spm[o];
    if (p < 21) return 8'((wc[(p-19)*8 + o/4] >> (8*(o%4))) & 255);
    if (p == 21) return (o < 4) ? 8'((hc >> (8*o)) & 255) : 8'h00;
    return 8'hFF;
  endfunction

  function automatic string rtag(int a);
    int p = a >> 5;
    if (p < 16) return "R2";
    if (p < 18) return "R4";
    if (p == 18) return "R3";
    if (p < 21) return "R7";
    if (p == 21) return "R8";
    return "R9";
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(int a, bit w, byte unsigned d, bit cg, int cp, bit hs, int sa, string tag);
    byte unsigned exp;
    addr = 10'(a); wr_en = w; wr_data = d; copy_go = cg; copy_page = 5'(cp);
    hash_start = hs; sec_addr = 6'(sa);
    exp = mread(a);
    @(posedge clk);
    if (cg) begin
      if (cp < 16) begin
        for (int i = 0; i < 32; i++) dm[cp*32 + i] = spm[i];
        if (cp >= 8) wc[cp-8]++;
      end else if (cp < 18) begin
        for (int i = 0; i < 32; i++) sm[(cp-16)*32 + i] = spm[i];
        for (int k = 0; k < 4; k++) wc[8 + (cp-16)*4 + k]++;
      end
    end
    if (w && (a >> 5) == 18) spm[a & 31] = d;
    if (hs) hc++;
    @(negedge clk);
    chk((tag == "") ? rtag(a) : tag, rd_data, exp);
    chk("R4", sec_data, sm[sa]);
  endtask

  task automatic rd(int a, string tag); step(a, 0, 0, 0, 0, 0, a & 63, tag); endtask
  task automatic wr(int a, byte unsigned d, string tag); step(a, 1, d, 0, 0, 0, 0, tag); endtask
  task automatic cp(int p, string tag); step(0, 0, 0, 1, p, 0, 0, tag); endtask

  initial begin
    #(8*150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    foreach (dm[i]) dm[i] = 0;
    foreach (sm[i]) sm[i] = 0;
    foreach (spm[i]) spm[i] = 0;
    foreach (wc[i]) wc[i] = 0;
    hc = 0;
    repeat (3) @(negedge clk);
    chk("R1", rd_data, 8'h00);
    rst_n = 1;
    foreach (dm[i]) dm[i] = 0;
    for (int p = 0; p < 32; p++) rd(p*32 + (p % 32), "R1");

    for (int o = 0; o < 32; o++) wr(18*32 + o, 8'(o*7 + 3), "R3");
    for (int o = 0; o < 32; o++) rd(18*32 + o, "R3");
    wr(3*32 + 5, 8'hA5, "R3"); rd(3*32 + 5, "R3");
    wr(19*32 + 0, 8'h55, "R3"); rd(19*32 + 0, "R3");
    wr(16*32 + 1, 8'h66, "R3"); rd(16*32 + 1, "R3");

    cp(3, "R2");
    for (int o = 0; o < 32; o++) rd(3*32 + o, "R2");
    for (int o = 0; o < 32; o++) rd(19*32 + o, "R5");

    cp(9, "R5"); wr(18*32, 8'h11, "R5"); cp(9, "R5");
    for (int o = 0; o < 8; o++) rd(19*32 + o, "R5");
    rd(9*32, "R2");

    for (int o = 0; o < 32; o++) wr(18*32 + o, 8'(255 - o*5), "R3");
    cp(17, "R6");
    for (int o = 0; o < 32; o++) rd(17*32 + o, "R4");
    for (int s = 0; s < 64; s++) step(0, 0, 0, 0, 0, 0, s, "R4");
    for (int o = 0; o < 32; o++) rd(20*32 + o, "R6");
    cp(16, "R6");
    for (int o = 0; o < 32; o++) rd(20*32 + o, "R6");

    cp(18, "R10"); cp(21, "R10"); cp(25, "R10"); cp(31, "R10");
    for (int o = 0; o < 32; o++) rd(19*32 + o, "R10");
    for (int o = 0; o < 32; o++) rd(21*32 + o, "R10");

    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 1, 0, "R8");
    step(0, 0, 0, 1, 12, 1, 0, "R8");
    for (int i = 0; i < 300; i++) step(21*32 + (i % 8), 0, 0, 0, 0, i % 3 == 0, 0, "R8");
    for (int o = 0; o < 8; o++) rd(21*32 + o, "R8");
    rd(19*32 + 16, "R5");

    step(18*32 + 2, 1, 8'hEE, 1, 5, 0, 0, "R2");
    rd(5*32 + 2, "R2");
    rd(18*32 + 2, "R3");

    for (int p = 22; p < 32; p++) begin
      rd(p*32, "R9"); rd(p*32 + 31, "R9");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule